// File: doc/BRIEF.md
# Remote Control Key Receiver

This block listens to a single asynchronous serial line carrying one-byte key codes from a handheld remote and turns each valid byte into a key event. The line idles high and runs at 9600 baud. Each character is framed as one low start bit, then eight data bits with the least significant bit first, then one high stop bit. The receiver samples the line at sixteen times the bit rate. It checks the start bit at its midpoint and takes every later bit at its centre.

A received byte is looked up in a small table of six key codes. A match yields a one-cycle key strobe with a three-bit key identifier. Every key event is also classified. If the same key arrived at the previous key event, less than a parameterised number of clock cycles earlier, the event is marked as a held (repeating) key. Otherwise it is marked as a fresh press. The default boundary is 0.75 s, which sits between the repeat rate of a held button (under 0.5 s) and the gap of about 1 s that separates two distinct presses.

Two further one-cycle strobes report problems. One reports a character whose stop bit is low. The other reports a byte that matches no table entry.

Top module: `remote_key_rx`

## Requirements
- R1: After reset, key_stb, key_held, frame_err and code_unknown are all 0, and key_id is 0.
- R2: Bytes are received as 8N1 with the least significant bit first. The key codes and the key_id values they produce are: 0xE0 gives 0 (volume down), 0xF0 gives 1 (volume up), 0xE8 gives 2 (next/plus), 0xE4 gives 3 (previous/minus), 0xE2 gives 4 (stop) and 0xE1 gives 5 (play).
- R3: Each accepted key produces exactly one key_stb pulse, one clock cycle wide, with key_id valid in that cycle.
- R4: A low pulse on the line that ends before the middle of the start bit is discarded and produces no strobe.
- R5: A character whose stop bit samples low produces one frame_err pulse and no key_stb.
- R6: A well-framed byte that is not one of the six codes produces one code_unknown pulse and no key_stb.
- R7: key_held is 1 with key_stb when the key equals the key of the previous key event and fewer than HOLD_CYCLES clock cycles have passed since that event. Unknown-code and framing-error characters do not disturb this history.
- R8: key_held is 0 for the first key after reset, for a key that differs from the previous one, and for a key arriving HOLD_CYCLES or more cycles after the previous key event.
- R9: A new character starts only on a high-to-low transition of the line. A line held low after a bad stop bit starts nothing until it has gone high again.
- R10: At most one of key_stb, frame_err and code_unknown is high in any cycle, and key_held is never high without key_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial line from the remote, idles high |
| key_id | output | 3 | Identifier of the decoded key, valid with key_stb |
| key_stb | output | 1 | One-cycle pulse for an accepted key |
| key_held | output | 1 | With key_stb: 1 for a repeat of a held key, 0 for a fresh press |
| frame_err | output | 1 | One-cycle pulse for a character with a low stop bit |
| code_unknown | output | 1 | One-cycle pulse for a byte not in the key table |

## Verification
A bit or oversample counter that slips by one sample shows up as a wrong key_id or as code_unknown on the very character where it happens. The bench therefore drives each of the six codes and compares the identifier. A receive state that fails to return to idle shows up at the ports as a missing strobe on the next character, which every scenario follows with a clean frame. A corrupted gap counter or stored last key shows up only in key_held, on the next key event. So held and fresh presses are tested with gaps well inside and well beyond the boundary, and with an unknown byte interleaved.

// File: rtl/remote_key_rx.sv
module remote_key_rx #(
  parameter int DIV         = 814,
  parameter int HOLD_CYCLES = 93_750_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx,
  output logic [2:0] key_id,
  output logic       key_stb,
  output logic       key_held,
  output logic       frame_err,
  output logic       code_unknown
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int GW = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} state_t;

  state_t        state;
  logic [2:0]    rx_sh;
  logic [DW-1:0] div_cnt;
  logic [3:0]    os_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg;
  logic [GW-1:0] gap;
  logic [2:0]    last_key;
  logic          have_last;
  logic          hit;
  logic [2:0]    id;

  wire rx_s   = rx_sh[1];
  wire rx_p   = rx_sh[2];
  wire tick   = (div_cnt == DW'(DIV - 1));
  wire mid    = tick && (os_cnt == 4'd15);
  wire done   = (state == S_STOP) && mid;
  wire good   = done && rx_s && hit;

  always_comb begin
    hit = 1'b1;
    id  = 3'd0;
    case (shreg)
      8'hE0:   id = 3'd0;
      8'hF0:   id = 3'd1;
      8'hE8:   id = 3'd2;
      8'hE4:   id = 3'd3;
      8'hE2:   id = 3'd4;
      8'hE1:   id = 3'd5;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= 3'b111;
      state   <= S_IDLE;
      div_cnt <= '0;
      os_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      rx_sh <= {rx_sh[1:0], rx};
      if (state == S_IDLE) begin
        div_cnt <= '0;
        os_cnt  <= '0;
        if (!rx_s && rx_p) state <= S_START;
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) os_cnt <= os_cnt + 1'b1;
        case (state)
          S_START:
            if (tick && os_cnt == 4'd7) begin
              os_cnt  <= '0;
              bit_cnt <= '0;
              state   <= rx_s ? S_IDLE : S_DATA;
            end
          S_DATA:
            if (mid) begin
              shreg   <= {rx_s, shreg[7:1]};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) state <= S_STOP;
            end
          default:
            if (mid) state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_id       <= '0;
      key_stb      <= 1'b0;
      key_held     <= 1'b0;
      frame_err    <= 1'b0;
      code_unknown <= 1'b0;
      gap          <= '0;
      last_key     <= '0;
      have_last    <= 1'b0;
    end else begin
      key_stb      <= good;
      frame_err    <= done && !rx_s;
      code_unknown <= done && rx_s && !hit;
      key_held     <= good && have_last && (last_key == id) && (gap < GW'(HOLD_CYCLES));
      if (good) begin
        key_id    <= id;
        last_key  <= id;
        have_last <= 1'b1;
        gap       <= '0;
      end else if (gap != GW'(HOLD_CYCLES)) begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

module remote_key_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] key_id,
  input logic       key_stb,
  input logic       key_held,
  input logic       frame_err,
  input logic       code_unknown
);
  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_stb, frame_err, code_unknown}));
  assert_held_needs_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_held |-> key_stb);
  assert_key_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_stb |=> !key_stb);
  assert_key_id_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_stb |-> (key_id <= 3'd5));
  assert_err_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  assert_unknown_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_unknown |=> !code_unknown);
endmodule

bind remote_key_rx remote_key_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .key_id(key_id), .key_stb(key_stb),
  .key_held(key_held), .frame_err(frame_err), .code_unknown(code_unknown)
);

// File: tb/remote_key_rx_test.sv
module remote_key_rx_test;
  localparam int DIV  = 4;
  localparam int HOLD = 3000;
  localparam int BIT  = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [2:0] key_id;
  logic key_stb, key_held, frame_err, code_unknown;

  int checks = 0, fails = 0;
  int n_key = 0, n_err = 0, n_unk = 0;
  logic [2:0] last_id = '0;
  logic last_held = 1'b0;

  always #4 clk = ~clk;

  remote_key_rx #(.DIV(DIV), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .key_id(key_id), .key_stb(key_stb),
    .key_held(key_held), .frame_err(frame_err), .code_unknown(code_unknown)
  );

  always @(negedge clk) begin
    if (key_stb) begin n_key++; last_id = key_id; last_held = key_held; end
    if (frame_err) n_err++;
    if (code_unknown) n_unk++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int low_after);
    rx = 1'b0; idle(BIT);
    for (int i = 0; i < 8; i++) begin rx = b[i]; idle(BIT); end
    rx = stop; idle(BIT);
    if (!stop) idle(low_after);
    rx = 1'b1; idle(BIT);
  endtask

  task automatic expect_key(input logic [7:0] b, input int exp_id, input bit exp_held, input string tag);
    int k0;
    k0 = n_key;
    send(b, 1'b1, 0);
    idle(16);
    check(n_key == k0 + 1, {tag, " key count"}, n_key - k0, 1);
    check(last_id == 3'(exp_id), {tag, " key_id"}, last_id, exp_id);
    check(last_held == exp_held, {tag, " key_held"}, last_held, exp_held);
  endtask

  task automatic t_reset;
    idle(2);
    check({key_stb, key_held, frame_err, code_unknown} == 4'b0, "R1 strobes", key_stb, 0);
    check(key_id == 3'd0, "R1 key_id", key_id, 0);
    rst_n = 1'b1;
    idle(50);
    check(n_key == 0 && n_err == 0 && n_unk == 0, "R1 quiet idle", n_key + n_err + n_unk, 0);
  endtask

  task automatic t_all_keys;
    expect_key(8'hE0, 0, 1'b0, "R2 R8 vol down first");
    expect_key(8'hF0, 1, 1'b0, "R2 R3 vol up");
    expect_key(8'hE8, 2, 1'b0, "R2 plus");
    expect_key(8'hE4, 3, 1'b0, "R2 minus");
    expect_key(8'hE2, 4, 1'b0, "R2 stop");
    expect_key(8'hE1, 5, 1'b0, "R2 play");
  endtask

  task automatic t_held;
    expect_key(8'hE1, 5, 1'b1, "R7 play repeat");
    expect_key(8'hE1, 5, 1'b1, "R7 play repeat again");
    idle(HOLD + 500);
    expect_key(8'hE1, 5, 1'b0, "R8 play after long gap");
  endtask

  task automatic t_unknown;
    int k0, u0;
    expect_key(8'hF0, 1, 1'b0, "R8 vol up new");
    k0 = n_key; u0 = n_unk;
    send(8'h55, 1'b1, 0);
    idle(16);
    check(n_unk == u0 + 1, "R6 unknown strobe", n_unk - u0, 1);
    check(n_key == k0, "R6 no key", n_key - k0, 0);
    expect_key(8'hF0, 1, 1'b1, "R7 repeat across unknown");
  endtask

  task automatic t_glitch;
    int k0, e0, u0;
    k0 = n_key; e0 = n_err; u0 = n_unk;
    rx = 1'b0; idle(DIV * 3);
    rx = 1'b1; idle(BIT * 12);
    check(n_key == k0 && n_err == e0 && n_unk == u0, "R4 glitch ignored",
          (n_key - k0) + (n_err - e0) + (n_unk - u0), 0);
    expect_key(8'hE8, 2, 1'b0, "R4 frame after glitch");
  endtask

  task automatic t_frame_err;
    int k0, e0, u0;
    k0 = n_key; e0 = n_err; u0 = n_unk;
    send(8'hE2, 1'b0, BIT * 4);
    idle(16);
    check(n_err == e0 + 1, "R5 R9 one frame_err", n_err - e0, 1);
    check(n_key == k0, "R5 no key on bad stop", n_key - k0, 0);
    check(n_unk == u0, "R9 no unknown while low", n_unk - u0, 0);
    expect_key(8'hE4, 3, 1'b0, "R9 frame after break");
  endtask

  initial begin
    t_reset();
    t_all_keys();
    t_held();
    t_unknown();
    t_glitch();
    t_frame_err();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule